// File: doc/BRIEF.md
# VLAN Membership Apply Sequencer

This block keeps a switch's VLAN configuration: a table of VLAN entries, each with a VLAN ID and a port-membership bitmap, plus a mask of ports that egress tagged and a default-VLAN index per port. Configuration software fills the table through a single write port. When `apply` is pulsed, the block pushes the whole configuration into the switch through a register-write master port.

The apply sequence has three parts. First it clears the VLAN translation unit (VTU) with a flush command. Then, if VLAN mode is on, it walks every table entry in ascending index order and loads each populated one into the VTU. While it walks, it accumulates, for each port, the set of ports that share a VLAN with it. Last, it writes a control word and a VLAN word for every port.

Every VTU command waits for the unit's busy status to clear. A busy status that never clears aborts the sequence and raises an error flag. With VLAN mode off, the ports are isolated from each other, and each can reach only the CPU port.

Top module: `vlan_apply_seq`

## Requirements
- R1: After reset, VID entry i holds i, every membership bitmap and the tagged mask are empty, every default-VLAN index is 0, VLAN mode is off, and `done`, `err` and `reg_wr` are low.
- R2: An apply starts with a VTU flush. This is a write with `reg_sel`=0 (VTU command) whose word has bit 31 (active) set, opcode 1 in bits [3:0], and zero in the VID field [27:16].
- R3: A VTU command sequence starts only after a cycle in which `vtu_busy` is sampled low. Up to 19 consecutive busy samples are tolerated without error.
- R4: After 20 consecutive busy samples, the sequence stops with no further register writes. `err` is set and `done` pulses in the cycle of the 20th sample plus one. `err` stays set until the next apply.
- R5: With VLAN mode on, entries are visited in ascending index order, and an entry with an empty bitmap is skipped. A populated entry produces two writes. The first is a data write (`reg_sel`=1) with the valid bit 31 set and the membership bitmap in the low bits. The second is a command write (`reg_sel`=0) with the active bit, the entry's VID in [27:16] and opcode 2.
- R6: With VLAN mode on, a port's destination mask is the union, over every populated VLAN it belongs to, of that VLAN's other members.
- R7: With VLAN mode off, no loads are issued. The CPU port's destination mask is every other port, and each other port's mask is the CPU port alone. Each port's default VID is its own port number, ingress mode is port-only (1), and egress mode is strip (1).
- R8: With VLAN mode on, a port's default VID is the VID entry selected by its default-VLAN index. Ingress mode is secure (3). Egress mode is add-tag (2) for ports in the tagged mask and strip (1) for all other ports.
- R9: Port words go out for port 0 upward. For each port there is a control write (`reg_sel`=2, egress mode in bits [1:0]) and then a VLAN write (`reg_sel`=3, default VID in [11:0], destination mask from bit 16, ingress mode in [31:30]). `reg_port` carries the port index on both writes. `done` pulses for one cycle, one cycle after the last write.
- R10: Table op 2 replaces entry `tbl_idx`'s bitmap with `tbl_members`. Members flagged in `tbl_tagged` join the tagged mask. Each untagged member leaves the tagged mask, takes `tbl_idx` as its default-VLAN index, and is removed from every other entry. Op 1 sets the entry's VID. Op 0 sets VLAN mode from `tbl_vid[0]`.
- R11: Table op 3 sets the default-VLAN index of port `tbl_port` to `tbl_idx`. A port number of NPORT or above is ignored.
- R12: While an apply is in progress, table writes and further `apply` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr | input | 1 | Table write strobe |
| tbl_op | input | 2 | Table operation: 0 mode, 1 VID, 2 membership, 3 default index |
| tbl_idx | input | 7 | VLAN entry index |
| tbl_port | input | 3 | Port number for operation 3 |
| tbl_vid | input | 12 | VID value, or mode in bit 0 |
| tbl_members | input | 6 | Membership bitmap |
| tbl_tagged | input | 6 | Tagged flags for the members |
| apply | input | 1 | Start of the apply sequence |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Busy-poll timeout flag |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 2 | Register selector |
| reg_port | output | 3 | Port index for per-port registers |
| reg_wdata | output | 32 | Register write data |
| vtu_busy | input | 1 | VTU busy status |

## Verification
The hardest situation to reach from the ports is the exact edge of the busy-poll window. The bench holds `vtu_busy` high from before the apply pulse and then releases it right after the 19th poll sample; the flush must still appear, with no error. In a second run it never releases busy; `done` must then arrive exactly 20 cycles after the apply, with `err` set and no write. Removing an untagged port from other VLANs is reached by moving a port that already sits untagged in one populated VLAN into another, and then checking the load words and the destination masks that follow.

// File: rtl/vlan_seq_pkg.sv
// Shared encodings for the VLAN apply sequencer.
// Assumes register words are 32 bits wide and at most 14 ports.
package vlan_seq_pkg;

    typedef enum logic [1:0] {
        TW_ENABLE = 2'd0,
        TW_VID    = 2'd1,
        TW_PORTS  = 2'd2,
        TW_PVID   = 2'd3
    } tbl_op_e;

    typedef enum logic [1:0] {
        RS_VTU_CMD   = 2'd0,
        RS_VTU_DATA  = 2'd1,
        RS_PORT_CTRL = 2'd2,
        RS_PORT_VLAN = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE, S_POLL, S_LDCMD, S_SCAN, S_PCTRL, S_PVLAN, S_DONE
    } seq_state_e;

    localparam int          WORD_W       = 32;
    localparam int          VID_LSB      = 16;
    localparam int          MASK_LSB     = 16;
    localparam int          FLAG_BIT     = 31;
    localparam int          ING_LSB      = 30;
    localparam logic [3:0]  VTU_OP_FLUSH = 4'd1;
    localparam logic [3:0]  VTU_OP_LOAD  = 4'd2;
    localparam logic [1:0]  EG_STRIP     = 2'd1;
    localparam logic [1:0]  EG_ADD       = 2'd2;
    localparam logic [1:0]  IN_PORT_ONLY = 2'd1;
    localparam logic [1:0]  IN_SECURE    = 2'd3;

endpackage

// File: rtl/vlan_seq_table.sv
// VLAN table storage: VID per entry, membership bitmaps, tagged mask,
// default-VLAN index per port, and the VLAN mode bit.
// Assumes the caller blocks writes while an apply is in progress.
module vlan_seq_table
    import vlan_seq_pkg::*;
#(
    parameter int NPORT = 6,
    parameter int NVLAN = 128,
    parameter int VID_W = 12,
    localparam int IDX_W  = $clog2(NVLAN),
    localparam int PORT_W = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_op,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [VID_W-1:0]  wr_vid,
    input  logic [NPORT-1:0]  wr_members,
    input  logic [NPORT-1:0]  wr_tagged,
    input  logic [IDX_W-1:0]  scan_idx,
    input  logic [PORT_W-1:0] port_sel,
    output logic              vlan_en,
    output logic [NPORT-1:0]  scan_members,
    output logic [VID_W-1:0]  scan_vid,
    output logic [NPORT-1:0]  tag_mask,
    output logic [VID_W-1:0]  port_vid
);

    logic [VID_W-1:0] vid_q   [NVLAN];
    logic [NPORT-1:0] mem_q   [NVLAN];
    logic [IDX_W-1:0] pidx_q  [NPORT];
    logic [NPORT-1:0] untag;
    logic [NPORT-1:0] tagd;

    // Split the written members into tagged and untagged sets.
    always_comb begin
        untag = wr_members & ~wr_tagged;
        tagd  = wr_members & wr_tagged;
    end

    // Table update under the write rules, with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vlan_en  <= 1'b0;
            tag_mask <= '0;
            for (int i = 0; i < NVLAN; i++) begin
                vid_q[i] <= VID_W'(i);
                mem_q[i] <= '0;
            end
            for (int p = 0; p < NPORT; p++) pidx_q[p] <= '0;
        end else if (wr_en) begin
            case (tbl_op_e'(wr_op))
                TW_ENABLE: vlan_en <= wr_vid[0];
                TW_VID:    vid_q[wr_idx] <= wr_vid;
                TW_PORTS: begin
                    tag_mask <= (tag_mask | tagd) & ~untag;
                    for (int j = 0; j < NVLAN; j++) begin
                        if (IDX_W'(j) == wr_idx) mem_q[j] <= wr_members;
                        else                     mem_q[j] <= mem_q[j] & ~untag;
                    end
                    for (int p = 0; p < NPORT; p++)
                        if (untag[p]) pidx_q[p] <= wr_idx;
                end
                TW_PVID: begin
                    if (int'(wr_port) < NPORT) pidx_q[wr_port] <= wr_idx;
                end
                default: ;
            endcase
        end
    end

    // Read ports for the entry walk and the per-port phase.
    always_comb begin
        scan_members = mem_q[scan_idx];
        scan_vid     = vid_q[scan_idx];
        port_vid     = vid_q[pidx_q[port_sel]];
    end

endmodule

// File: rtl/vlan_seq_poll.sv
// Busy-status poller: counts consecutive busy samples while polling and
// flags a timeout on the POLL_LIMIT-th one.
// Assumes polling drops for at least one cycle between two polls.
module vlan_seq_poll #(
    parameter int POLL_LIMIT = 20,
    localparam int CNT_W = $clog2(POLL_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic polling,
    input  logic busy,
    output logic go,
    output logic timeout
);

    logic [CNT_W-1:0] cnt;

    // Count busy samples; clear whenever no poll is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || !polling) cnt <= '0;
        else if (busy)          cnt <= cnt + 1'b1;
    end

    // Decide between proceeding and giving up.
    always_comb begin
        go      = polling && !busy;
        timeout = polling && busy && (cnt == CNT_W'(POLL_LIMIT - 1));
    end

endmodule

// File: rtl/vlan_seq_ctrl.sv
// Apply sequencer: flush, entry walk with mask accumulation and loads,
// then the per-port control and VLAN words. All outputs are registered.
// Assumes the table is stable while the sequence runs.
module vlan_seq_ctrl
    import vlan_seq_pkg::*;
#(
    parameter int NPORT    = 6,
    parameter int NVLAN    = 128,
    parameter int VID_W    = 12,
    parameter int CPU_PORT = 0,
    localparam int IDX_W  = $clog2(NVLAN),
    localparam int PORT_W = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic              vlan_en,
    input  logic [NPORT-1:0]  scan_members,
    input  logic [VID_W-1:0]  scan_vid,
    input  logic [NPORT-1:0]  tag_mask,
    input  logic [VID_W-1:0]  port_vid,
    input  logic              poll_go,
    input  logic              poll_timeout,
    output logic [IDX_W-1:0]  scan_idx,
    output logic [PORT_W-1:0] port_idx,
    output logic              polling,
    output logic              seq_busy,
    output logic              reg_wr,
    output logic [1:0]        reg_sel,
    output logic [PORT_W-1:0] reg_port,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              done,
    output logic              err
);

    seq_state_e       state;
    logic             load_phase;
    logic [NPORT-1:0] dmask [NPORT];
    logic             scan_last;
    logic             port_last;
    logic [WORD_W-1:0] ctrl_word, vlan_word, data_word;
    logic [NPORT-1:0]  pmask;
    logic [VID_W-1:0]  dvid;
    logic [1:0]        eg, ing;

    // Build a VTU command word with the active bit set.
    function automatic logic [WORD_W-1:0] vtu_cmd(input logic [VID_W-1:0] vid,
                                                  input logic [3:0] op);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FLAG_BIT] = 1'b1;
        w[VID_LSB +: VID_W] = vid;
        w[3:0] = op;
        return w;
    endfunction

    // Status views of the walk position and the state.
    always_comb begin
        scan_last = (scan_idx == IDX_W'(NVLAN - 1));
        port_last = (port_idx == PORT_W'(NPORT - 1));
        polling   = (state == S_POLL);
        seq_busy  = (state != S_IDLE);
    end

    // Per-port and data words for the current position.
    always_comb begin
        if (vlan_en) begin
            pmask = dmask[port_idx];
            dvid  = port_vid;
            ing   = IN_SECURE;
            eg    = tag_mask[port_idx] ? EG_ADD : EG_STRIP;
        end else begin
            pmask = (port_idx == PORT_W'(CPU_PORT)) ? ~(NPORT'(1) << CPU_PORT)
                                                    :  (NPORT'(1) << CPU_PORT);
            dvid  = VID_W'(port_idx);
            ing   = IN_PORT_ONLY;
            eg    = EG_STRIP;
        end
        ctrl_word = '0;
        ctrl_word[1:0] = eg;
        vlan_word = '0;
        vlan_word[VID_W-1:0] = dvid;
        vlan_word[MASK_LSB +: NPORT] = pmask;
        vlan_word[ING_LSB +: 2] = ing;
        data_word = '0;
        data_word[FLAG_BIT] = 1'b1;
        data_word[NPORT-1:0] = scan_members;
    end

    // Sequence state machine and registered master-port outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            scan_idx   <= '0;
            port_idx   <= '0;
            load_phase <= 1'b0;
            reg_wr     <= 1'b0;
            reg_sel    <= RS_VTU_CMD;
            reg_port   <= '0;
            reg_wdata  <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
            for (int p = 0; p < NPORT; p++) dmask[p] <= '0;
        end else begin
            reg_wr <= 1'b0;
            done   <= 1'b0;
            case (state)
                S_IDLE: if (apply) begin
                    err        <= 1'b0;
                    scan_idx   <= '0;
                    port_idx   <= '0;
                    load_phase <= 1'b0;
                    for (int p = 0; p < NPORT; p++) dmask[p] <= '0;
                    state      <= S_POLL;
                end
                S_POLL: begin
                    if (poll_timeout) begin
                        err   <= 1'b1;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (poll_go) begin
                        reg_wr   <= 1'b1;
                        reg_port <= '0;
                        if (!load_phase) begin
                            reg_sel   <= RS_VTU_CMD;
                            reg_wdata <= vtu_cmd('0, VTU_OP_FLUSH);
                            state     <= vlan_en ? S_SCAN : S_PCTRL;
                        end else begin
                            reg_sel   <= RS_VTU_DATA;
                            reg_wdata <= data_word;
                            state     <= S_LDCMD;
                        end
                    end
                end
                S_LDCMD: begin
                    reg_wr    <= 1'b1;
                    reg_sel   <= RS_VTU_CMD;
                    reg_port  <= '0;
                    reg_wdata <= vtu_cmd(scan_vid, VTU_OP_LOAD);
                    if (scan_last) state <= S_PCTRL;
                    else begin
                        scan_idx <= scan_idx + 1'b1;
                        state    <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (|scan_members) begin
                        load_phase <= 1'b1;
                        for (int p = 0; p < NPORT; p++)
                            if (scan_members[p])
                                dmask[p] <= dmask[p] | (scan_members & ~(NPORT'(1) << p));
                        state <= S_POLL;
                    end else if (scan_last) begin
                        state <= S_PCTRL;
                    end else begin
                        scan_idx <= scan_idx + 1'b1;
                    end
                end
                S_PCTRL: begin
                    reg_wr    <= 1'b1;
                    reg_sel   <= RS_PORT_CTRL;
                    reg_port  <= port_idx;
                    reg_wdata <= ctrl_word;
                    state     <= S_PVLAN;
                end
                S_PVLAN: begin
                    reg_wr    <= 1'b1;
                    reg_sel   <= RS_PORT_VLAN;
                    reg_port  <= port_idx;
                    reg_wdata <= vlan_word;
                    if (port_last) state <= S_DONE;
                    else begin
                        port_idx <= port_idx + 1'b1;
                        state    <= S_PCTRL;
                    end
                end
                S_DONE: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vlan_apply_seq.sv
// Top of the VLAN apply sequencer: table, busy poller and sequencer.
// Assumes NPORT <= 14 so the port fields fit the 32-bit register words.
module vlan_apply_seq
    import vlan_seq_pkg::*;
#(
    parameter int NPORT      = 6,
    parameter int NVLAN      = 128,
    parameter int VID_W      = 12,
    parameter int CPU_PORT   = 0,
    parameter int POLL_LIMIT = 20,
    localparam int IDX_W  = $clog2(NVLAN),
    localparam int PORT_W = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr,
    input  logic [1:0]        tbl_op,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [PORT_W-1:0] tbl_port,
    input  logic [VID_W-1:0]  tbl_vid,
    input  logic [NPORT-1:0]  tbl_members,
    input  logic [NPORT-1:0]  tbl_tagged,
    input  logic              apply,
    output logic              done,
    output logic              err,
    output logic              reg_wr,
    output logic [1:0]        reg_sel,
    output logic [PORT_W-1:0] reg_port,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic              vtu_busy
);

    logic              seq_busy, polling, poll_go, poll_timeout, vlan_en;
    logic [IDX_W-1:0]  scan_idx;
    logic [PORT_W-1:0] port_idx;
    logic [NPORT-1:0]  scan_members, tag_mask;
    logic [VID_W-1:0]  scan_vid, port_vid;

    vlan_seq_table #(.NPORT(NPORT), .NVLAN(NVLAN), .VID_W(VID_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr && !seq_busy), .wr_op(tbl_op),
        .wr_idx(tbl_idx), .wr_port(tbl_port), .wr_vid(tbl_vid),
        .wr_members(tbl_members), .wr_tagged(tbl_tagged),
        .scan_idx(scan_idx), .port_sel(port_idx), .vlan_en(vlan_en),
        .scan_members(scan_members), .scan_vid(scan_vid),
        .tag_mask(tag_mask), .port_vid(port_vid)
    );

    vlan_seq_poll #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .polling(polling), .busy(vtu_busy),
        .go(poll_go), .timeout(poll_timeout)
    );

    vlan_seq_ctrl #(.NPORT(NPORT), .NVLAN(NVLAN), .VID_W(VID_W),
                    .CPU_PORT(CPU_PORT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .apply(apply), .vlan_en(vlan_en),
        .scan_members(scan_members), .scan_vid(scan_vid),
        .tag_mask(tag_mask), .port_vid(port_vid),
        .poll_go(poll_go), .poll_timeout(poll_timeout),
        .scan_idx(scan_idx), .port_idx(port_idx), .polling(polling),
        .seq_busy(seq_busy), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_port(reg_port), .reg_wdata(reg_wdata), .done(done), .err(err)
    );

endmodule

// File: rtl/vlan_apply_seq_chk.sv
// Protocol checker for the master port of vlan_apply_seq, bound below.
module vlan_apply_seq_chk #(
    parameter int NPORT = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        vtu_busy,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        done,
    input logic        err
);

    // R3: a flush or a load data word follows a sample with busy low
    a_r3_vtu_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == 2'd1 || (reg_sel == 2'd0 && reg_wdata[3:0] == 4'd1)))
        |-> !$past(vtu_busy));

    a_r2_active_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |-> reg_wdata[31]);

    a_r5_load_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && reg_wdata[3:0] == 4'd2)
        |-> $past(reg_wr && reg_sel == 2'd1));

    a_r5_data_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1) |-> (reg_wdata[31] && (|reg_wdata[NPORT-1:0])));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !reg_wr);

    a_r4_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (done && !reg_wr));

endmodule

bind vlan_apply_seq vlan_apply_seq_chk #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .vtu_busy(vtu_busy), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .done(done), .err(err)
);

// File: tb/sim_vlan_apply_seq.sv
module sim_vlan_apply_seq;
    localparam int NPORT = 6;
    localparam int NVLAN = 128;
    localparam int CPU   = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [1:0]  tbl_op = '0;
    logic [6:0]  tbl_idx = '0;
    logic [2:0]  tbl_port = '0;
    logic [11:0] tbl_vid = '0;
    logic [5:0]  tbl_members = '0;
    logic [5:0]  tbl_tagged = '0;
    logic        apply = 1'b0;
    logic        vtu_busy = 1'b0;
    logic        done, err, reg_wr;
    logic [1:0]  reg_sel;
    logic [2:0]  reg_port;
    logic [31:0] reg_wdata;

    always #10 clk = ~clk;

    vlan_apply_seq u0 (
        .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_op(tbl_op),
        .tbl_idx(tbl_idx), .tbl_port(tbl_port), .tbl_vid(tbl_vid),
        .tbl_members(tbl_members), .tbl_tagged(tbl_tagged), .apply(apply),
        .done(done), .err(err), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_port(reg_port), .reg_wdata(reg_wdata), .vtu_busy(vtu_busy)
    );

    typedef struct {
        logic [1:0]  sel;
        logic [2:0]  port;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int n_chk = 0;
    int n_fail = 0;

    logic        m_en;
    logic [11:0] m_vid [NVLAN];
    logic [5:0]  m_mem [NVLAN];
    logic [5:0]  m_tag;
    logic [6:0]  m_pidx [NPORT];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] sel, input int port,
                        input logic [31:0] data, input string tag);
        exp_t e;
        e.sel = sel; e.port = 3'(port); e.data = data; e.tag = tag;
        expq.push_back(e);
    endtask

    // Monitor: pops the scoreboard on every register write.
    exp_t got;
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4", "unexpected register write", reg_wdata, 32'h0);
            end else begin
                got = expq.pop_front();
                check(reg_sel == got.sel && reg_port == got.port && reg_wdata == got.data,
                      got.tag, $sformatf("write sel=%0d port=%0d", reg_sel, reg_port),
                      reg_wdata, got.data);
            end
        end
    end

    task automatic model_reset();
        m_en = 1'b0;
        m_tag = '0;
        for (int i = 0; i < NVLAN; i++) begin
            m_vid[i] = 12'(i);
            m_mem[i] = '0;
        end
        for (int p = 0; p < NPORT; p++) m_pidx[p] = '0;
    endtask

    // Driver for the table port; upd=1 also applies the rule to the model.
    task automatic tbl_write(input int op, input int idx, input int port,
                             input logic [11:0] vid, input logic [5:0] mem,
                             input logic [5:0] tg, input bit upd);
        logic [5:0] un;
        @(negedge clk);
        tbl_wr = 1'b1; tbl_op = 2'(op); tbl_idx = 7'(idx); tbl_port = 3'(port);
        tbl_vid = vid; tbl_members = mem; tbl_tagged = tg;
        @(negedge clk);
        tbl_wr = 1'b0;
        if (upd) begin
            un = mem & ~tg;
            case (op)
                0: m_en = vid[0];
                1: m_vid[idx] = vid;
                2: begin
                    m_tag = (m_tag | (mem & tg)) & ~un;
                    for (int j = 0; j < NVLAN; j++)
                        m_mem[j] = (j == idx) ? mem : (m_mem[j] & ~un);
                    for (int p = 0; p < NPORT; p++) if (un[p]) m_pidx[p] = 7'(idx);
                end
                default: if (port < NPORT) m_pidx[port] = 7'(idx);
            endcase
        end
    endtask

    // Expected write stream of one successful apply (R2, R5-R9).
    task automatic expect_apply();
        logic [5:0] dm [NPORT];
        logic [11:0] dvid;
        logic [1:0] ing, eg;
        push(2'd0, 0, 32'h8000_0001, "R2");
        for (int p = 0; p < NPORT; p++) dm[p] = '0;
        if (m_en) begin
            for (int j = 0; j < NVLAN; j++) begin
                if (m_mem[j] != 0) begin
                    push(2'd1, 0, 32'h8000_0000 | 32'(m_mem[j]), "R5");
                    push(2'd0, 0, 32'h8000_0002 | (32'(m_vid[j]) << 16), "R5");
                    for (int p = 0; p < NPORT; p++)
                        if (m_mem[j][p]) dm[p] = dm[p] | (m_mem[j] & ~(6'd1 << p));
                end
            end
        end else begin
            for (int p = 0; p < NPORT; p++)
                dm[p] = (p == CPU) ? (6'h3f & ~(6'd1 << CPU)) : (6'd1 << CPU);
        end
        for (int p = 0; p < NPORT; p++) begin
            dvid = m_en ? m_vid[m_pidx[p]] : 12'(p);
            ing  = m_en ? 2'd3 : 2'd1;
            eg   = (m_en && m_tag[p]) ? 2'd2 : 2'd1;
            push(2'd2, p, 32'(eg), m_en ? "R8" : "R7");
            push(2'd3, p, (32'(ing) << 30) | (32'(dm[p]) << 16) | 32'(dvid),
                 m_en ? "R6" : "R7");
        end
    endtask

    // Pulse apply, optionally hold busy, then wait for done and check.
    task automatic run_apply(input int hold, input bit exp_err, input bit inject);
        int cyc;
        bit seen;
        if (hold != 0) vtu_busy = 1'b1;
        @(negedge clk); apply = 1'b1;
        @(negedge clk); apply = 1'b0;
        if (inject) begin
            tbl_write(0, 0, 0, 12'h000, 6'h00, 6'h00, 1'b0);
            tbl_write(2, 3, 0, 12'h000, 6'h3f, 6'h00, 1'b0);
            @(negedge clk); apply = 1'b1;
            @(negedge clk); apply = 1'b0;
        end
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            vtu_busy = 1'b0;
        end
        cyc = 0; seen = 1'b0;
        while (!seen && cyc < 3000) begin
            if (done) seen = 1'b1;
            else begin @(negedge clk); cyc++; end
        end
        check(seen, "R9", "done pulse seen", 32'(seen), 32'd1);
        check(err == exp_err, exp_err ? "R4" : "R3", "err flag", 32'(err), 32'(exp_err));
        if (hold < 0) check(cyc == 20, "R4", "cycles to abort", 32'(cyc), 32'd20);
        check(expq.size() == 0, "R9", "writes left outstanding", 32'(expq.size()), 32'd0);
        vtu_busy = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(!done && !err && !reg_wr, "R1", "reset outputs",
              {29'd0, done, err, reg_wr}, 32'd0);

        // R7, R2: VLAN mode off after reset gives the CPU star
        expect_apply();
        run_apply(0, 1'b0, 1'b0);

        // R1, R8: VLAN mode on with an empty table, VID entry 0 is 0
        tbl_write(0, 0, 0, 12'h001, 6'h00, 6'h00, 1'b1);
        expect_apply();
        run_apply(0, 1'b0, 1'b0);

        // R10, R5, R6, R8: several VLANs, entry 7 and 127 keep reset VIDs (R1)
        tbl_write(2, 7, 0, 12'h000, 6'b000011, 6'b000001, 1'b1);
        tbl_write(1, 3, 0, 12'd100, 6'h00, 6'h00, 1'b1);
        tbl_write(2, 3, 0, 12'h000, 6'b001101, 6'b000001, 1'b1);
        tbl_write(1, 9, 0, 12'hABC, 6'h00, 6'h00, 1'b1);
        tbl_write(2, 9, 0, 12'h000, 6'b110000, 6'b000000, 1'b1);
        tbl_write(2, 127, 0, 12'h000, 6'b000001, 6'b000001, 1'b1);
        expect_apply();
        run_apply(0, 1'b0, 1'b0);

        // R10: port 2 moves untagged into entry 9; R3: 19 busy samples tolerated
        tbl_write(2, 9, 0, 12'h000, 6'b110100, 6'b000000, 1'b1);
        expect_apply();
        run_apply(19, 1'b0, 1'b0);

        // R11: default index of port 0 changes; port 7 is out of range
        tbl_write(3, 9, 0, 12'h000, 6'h00, 6'h00, 1'b1);
        tbl_write(3, 3, 7, 12'h000, 6'h00, 6'h00, 1'b1);
        expect_apply();
        run_apply(0, 1'b0, 1'b0);

        // R4: busy never clears, abort without writes
        run_apply(-1, 1'b1, 1'b0);

        // R12: writes and apply during a run are ignored; R4: err clears
        expect_apply();
        run_apply(0, 1'b0, 1'b1);
        expect_apply();
        run_apply(0, 1'b0, 1'b0);

        // R7: VLAN mode off again with a populated table
        tbl_write(0, 0, 0, 12'h000, 6'h00, 6'h00, 1'b1);
        expect_apply();
        run_apply(0, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule